// File: doc/BRIEF.md
# DAC Channel Sample Source Selector

This block produces one sample stream for each DAC channel. A 4-bit code for each channel picks where that channel's samples come from. The choices are the DMA stream, the loopback data from an external converter, a constant zero, PN7 or PN15 pseudo-random words (true or inverted), a nibble ramp and a full-width ramp. The serial transfer controller issues a `sample_en` strobe. On each strobe, every channel registers its next sample. Between strobes the outputs hold their value. The generators are shared by all channels and step once per strobe, whatever the channels have selected.

A synchronisation gate lets several instances start DMA streaming on the same strobe. Software pulses `arm_set`. While the gate is armed, `dma_ready` stays low and channels that select DMA output zero. The gate raises `sync_out` when it is armed, at least one channel selects DMA, and both the primary and the secondary DMA valid are high. Other instances take this signal on `ext_sync_in`, and a single instance can loop it back to itself. A pulse on `ext_sync_in` disarms the gate. DMA data then flows from the next strobe on.

Top module: `dac_src_select`

## Requirements
- R1: After a synchronous active-low reset, every channel output is zero, `armed` is 0, `dma_ready` is 1 and `sync_out` is 0.
- R2: Channel outputs change only at a clock edge where `sample_en` is 1. Otherwise they hold their value, whatever the select codes or data inputs do.
- R3: Code 0x2 outputs the channel's DMA word when the gate is not armed and both `dma_valid` and `dma_valid_sec` are 1. Otherwise it outputs zero.
- R4: Code 0x8 outputs the channel's loopback word. Code 0x3 outputs zero.
- R5: Code 0x6 outputs PN7 words (x^7+x^6+1). The generator state starts at all ones. Each step computes feedback = s[6]^s[5] and shifts it into s[0]. A word is the next 16 feedback bits, with the first bit in the MSB. Code 0x4 outputs the bitwise inverse of the same word.
- R6: Code 0x7 outputs PN15 words (x^15+x^14+1). The construction is the same as for PN7, with feedback = s[14]^s[13] and an all-ones start. Code 0x5 outputs the inverse.
- R7: Code 0xB outputs k mod 65536 on the k-th strobe after reset, counting from 0, so the value wraps from 0xFFFF to 0x0000.
- R8: Code 0xA outputs the value (k mod 16) copied into all four nibbles.
- R9: Codes 0x0, 0x1, 0x9 and 0xC to 0xF output zero.
- R10: Each channel follows its own select code (channel c uses bits [4c+3:4c]), independently of the other channel.
- R11: A pulse on `arm_set` sets `armed`, which drives `dma_ready` to 0. While armed, DMA-selecting channels output zero.
- R12: `sync_out` is 1 exactly when the gate is armed, some channel selects code 0x2, and both DMA valids are 1.
- R13: An `ext_sync_in` pulse while armed clears `armed` at that edge. `arm_set` wins if both arrive in the same cycle. `ext_sync_in` has no effect while not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe that advances all channels |
| chan_sel | input | 4*CH_N | Select code for each channel |
| dma_data | input | 16*CH_N | DMA word for each channel |
| dma_valid | input | 1 | Primary DMA valid |
| dma_valid_sec | input | 1 | Secondary DMA valid |
| lb_data | input | 16*CH_N | Loopback word for each channel |
| arm_set | input | 1 | Arms the sync gate |
| ext_sync_in | input | 1 | Sync event that releases the gate |
| sync_out | output | 1 | Start request toward other instances |
| armed | output | 1 | Gate armed state |
| dma_ready | output | 1 | DMA may deliver data |
| dout | output | 16*CH_N | Registered sample for each channel |

## Verification
The bench sets different codes on the two channels in the same strobe. This tells a crossed select field or a shared output register apart from correct behaviour. It runs long PN7 and PN15 stretches, with true and inverted words paired on the two channels. These separate a wrong tap, a wrong bit order or a missing inversion, and they show whether the state advances across words. More than 65536 back-to-back strobes push the ramps through wrap-around. The gate is driven through armed, released, simultaneous arm-and-sync and spurious-sync cases, with each valid dropped in turn. This checks that DMA data, `sync_out` and `dma_ready` depend on exactly the inputs stated.

// File: rtl/dac_srcsel_pkg.sv
// Shared select-code definitions for the per-channel sample source selector.
// Assumes a 4-bit code per channel; any code not listed selects zero.
package dac_srcsel_pkg;

    typedef enum logic [3:0] {
        SRC_DMA       = 4'h2,
        SRC_ZERO      = 4'h3,
        SRC_PN7_INV   = 4'h4,
        SRC_PN15_INV  = 4'h5,
        SRC_PN7       = 4'h6,
        SRC_PN15      = 4'h7,
        SRC_LOOPBACK  = 4'h8,
        SRC_NIB_RAMP  = 4'hA,
        SRC_FULL_RAMP = 4'hB
    } src_code_e;

    localparam int SEL_W = 4;

endpackage

// File: rtl/pn_seq_gen.sv
// Pseudo-random word generator (Fibonacci LFSR, polynomial x^ORDER + x^TAP + 1).
// The word output is the next WORD_W feedback bits, first bit in the MSB.
// The state advances by WORD_W steps on each 'adv' strobe.
// Assumes 0 < TAP < ORDER. The state starts at all ones and never becomes zero.
module pn_seq_gen #(
    parameter int ORDER  = 7,
    parameter int TAP    = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [WORD_W-1:0] word
);
    localparam int PACK_W = ORDER + WORD_W;

    logic [ORDER-1:0]  state_q;
    logic [PACK_W-1:0] step_w;

    // Runs the LFSR WORD_W steps and returns {next state, word}.
    function automatic logic [PACK_W-1:0] run_word(input logic [ORDER-1:0] s_in);
        logic [ORDER-1:0]  s;
        logic [WORD_W-1:0] w;
        logic              fb;
        s = s_in;
        w = '0;
        for (int i = 0; i < WORD_W; i++) begin
            fb = s[ORDER-1] ^ s[TAP-1];
            w  = {w[WORD_W-2:0], fb};
            s  = {s[ORDER-2:0], fb};
        end
        return {s, w};
    endfunction

    assign step_w = run_word(state_q);
    assign word   = step_w[WORD_W-1:0];

    // Holds the LFSR state and steps it once per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   state_q <= '1;
        else if (adv) state_q <= step_w[PACK_W-1:WORD_W];
    end

    // R5 / R6
    pn_state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/ramp_gen.sv
// Sample counter that provides both ramp patterns.
// full_word is the count itself. nib_word repeats the low four count bits in every nibble.
// Assumes WORD_W is a multiple of 4.
module ramp_gen #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [WORD_W-1:0] full_word,
    output logic [WORD_W-1:0] nib_word
);
    localparam int NIB_N = WORD_W / 4;

    logic [WORD_W-1:0] cnt_q;

    // Counts strobes and wraps naturally at the width limit.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (adv) cnt_q <= cnt_q + 1'b1;
    end

    assign full_word = cnt_q;
    assign nib_word  = {NIB_N{cnt_q[3:0]}};

    // R7
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> cnt_q == $past(cnt_q) + 1'b1);

    // R7
    ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt_q));

endmodule

// File: rtl/sync_gate.sv
// Multi-device start gate for DMA streaming.
// arm_set arms the gate, and ext_sync_in disarms it when arm_set is not active in the same cycle.
// sync_out asks peers (or this instance, through a loop) to release.
// Assumes arm_set and ext_sync_in are single-cycle pulses in the clk domain.
module sync_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_set,
    input  logic ext_sync_in,
    input  logic dma_valid,
    input  logic dma_valid_sec,
    input  logic dma_in_use,
    output logic armed,
    output logic sync_out,
    output logic dma_ready
);
    logic armed_q;

    // Armed flag: setting wins over releasing.
    always_ff @(posedge clk) begin
        if (!rst_n)           armed_q <= 1'b0;
        else if (arm_set)     armed_q <= 1'b1;
        else if (ext_sync_in) armed_q <= 1'b0;
    end

    assign armed     = armed_q;
    assign sync_out  = armed_q & dma_valid & dma_valid_sec & dma_in_use;
    assign dma_ready = ~armed_q;

    // R13
    arm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_set |=> armed_q);

    // R13
    sync_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ext_sync_in && !arm_set |=> !armed_q);

    // R11
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !ext_sync_in |=> armed_q);

endmodule

// File: rtl/chan_src_mux.sv
// Output stage for one channel: picks a source by code and registers it on sample_en.
// DMA words pass only when the gate is open and both DMA valids are high.
// Assumes the generator words are the values for the current strobe.
module chan_src_mux
    import dac_srcsel_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] dma_word,
    input  logic              dma_valid,
    input  logic              dma_valid_sec,
    input  logic              armed,
    input  logic [WORD_W-1:0] lb_word,
    input  logic [WORD_W-1:0] pn7_word,
    input  logic [WORD_W-1:0] pn15_word,
    input  logic [WORD_W-1:0] ramp_word,
    input  logic [WORD_W-1:0] nib_word,
    output logic [WORD_W-1:0] dout
);
    logic [WORD_W-1:0] pick_w;
    logic [WORD_W-1:0] dout_q;
    logic              dma_ok_w;

    assign dma_ok_w = ~armed & dma_valid & dma_valid_sec;

    // Source decode; codes not in the map give zero.
    always_comb begin
        case (sel)
            SRC_DMA:       pick_w = dma_ok_w ? dma_word : '0;
            SRC_ZERO:      pick_w = '0;
            SRC_PN7_INV:   pick_w = ~pn7_word;
            SRC_PN15_INV:  pick_w = ~pn15_word;
            SRC_PN7:       pick_w = pn7_word;
            SRC_PN15:      pick_w = pn15_word;
            SRC_LOOPBACK:  pick_w = lb_word;
            SRC_NIB_RAMP:  pick_w = nib_word;
            SRC_FULL_RAMP: pick_w = ramp_word;
            default:       pick_w = '0;
        endcase
    end

    // Output register, loaded once per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         dout_q <= '0;
        else if (sample_en) dout_q <= pick_w;
    end

    assign dout = dout_q;

    // R11
    dma_gated_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && sel == SRC_DMA && armed |=> dout_q == '0);

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && (sel inside {4'h0, 4'h1, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF}) |=> dout_q == '0);

    // R4
    loopback_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && sel == SRC_LOOPBACK |=> dout_q == $past(lb_word));

endmodule

// File: rtl/dac_src_select.sv
// Top of the per-channel DAC sample source selector.
// Shared PN7, PN15 and ramp generators step on each sample_en strobe.
// Each channel has its own select field and output register.
// A sync gate holds DMA data back until a release event arrives.
// Assumes sample_en and all inputs are synchronous to clk.
module dac_src_select
    import dac_srcsel_pkg::*;
#(
    parameter int CH_N     = 2,
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_en,
    input  logic [CH_N*SEL_W-1:0]      chan_sel,
    input  logic [CH_N*SAMPLE_W-1:0]   dma_data,
    input  logic                       dma_valid,
    input  logic                       dma_valid_sec,
    input  logic [CH_N*SAMPLE_W-1:0]   lb_data,
    input  logic                       arm_set,
    input  logic                       ext_sync_in,
    output logic                       sync_out,
    output logic                       armed,
    output logic                       dma_ready,
    output logic [CH_N*SAMPLE_W-1:0]   dout
);
    localparam int PN7_ORDER  = 7;
    localparam int PN7_TAP    = 6;
    localparam int PN15_ORDER = 15;
    localparam int PN15_TAP   = 14;

    logic [SAMPLE_W-1:0] pn7_w;
    logic [SAMPLE_W-1:0] pn15_w;
    logic [SAMPLE_W-1:0] ramp_w;
    logic [SAMPLE_W-1:0] nib_w;
    logic [CH_N-1:0]     uses_dma_w;
    logic                armed_w;

    pn_seq_gen #(.ORDER(PN7_ORDER), .TAP(PN7_TAP), .WORD_W(SAMPLE_W)) u_pn7 (
        .clk(clk), .rst_n(rst_n), .adv(sample_en), .word(pn7_w)
    );

    pn_seq_gen #(.ORDER(PN15_ORDER), .TAP(PN15_TAP), .WORD_W(SAMPLE_W)) u_pn15 (
        .clk(clk), .rst_n(rst_n), .adv(sample_en), .word(pn15_w)
    );

    ramp_gen #(.WORD_W(SAMPLE_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .adv(sample_en),
        .full_word(ramp_w), .nib_word(nib_w)
    );

    sync_gate u_gate (
        .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .ext_sync_in(ext_sync_in),
        .dma_valid(dma_valid), .dma_valid_sec(dma_valid_sec),
        .dma_in_use(|uses_dma_w), .armed(armed_w),
        .sync_out(sync_out), .dma_ready(dma_ready)
    );

    assign armed = armed_w;

    for (genvar c = 0; c < CH_N; c++) begin : g_chan
        assign uses_dma_w[c] = (chan_sel[c*SEL_W +: SEL_W] == SRC_DMA);

        chan_src_mux #(.WORD_W(SAMPLE_W)) u_mux (
            .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
            .sel(chan_sel[c*SEL_W +: SEL_W]),
            .dma_word(dma_data[c*SAMPLE_W +: SAMPLE_W]),
            .dma_valid(dma_valid), .dma_valid_sec(dma_valid_sec),
            .armed(armed_w),
            .lb_word(lb_data[c*SAMPLE_W +: SAMPLE_W]),
            .pn7_word(pn7_w), .pn15_word(pn15_w),
            .ramp_word(ramp_w), .nib_word(nib_w),
            .dout(dout[c*SAMPLE_W +: SAMPLE_W])
        );
    end

    // R2
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(dout));

endmodule

// File: tb/dac_src_select_tb_top.sv
module dac_src_select_tb_top;
    import dac_srcsel_pkg::*;

    localparam int CH_N = 2;
    localparam int W    = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_en = 1'b0;
    logic [2*4-1:0]    chan_sel = '0;
    logic [2*W-1:0]    dma_data = '0;
    logic              dma_valid = 1'b0;
    logic              dma_valid_sec = 1'b0;
    logic [2*W-1:0]    lb_data = '0;
    logic              arm_set = 1'b0;
    logic              ext_sync_in = 1'b0;
    logic              sync_out;
    logic              armed;
    logic              dma_ready;
    logic [2*W-1:0]    dout;

    always #4 clk = ~clk;

    dac_src_select #(.CH_N(CH_N), .SAMPLE_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .chan_sel(chan_sel),
        .dma_data(dma_data), .dma_valid(dma_valid), .dma_valid_sec(dma_valid_sec),
        .lb_data(lb_data), .arm_set(arm_set), .ext_sync_in(ext_sync_in),
        .sync_out(sync_out), .armed(armed), .dma_ready(dma_ready), .dout(dout)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic fired = 1'b0;

    logic [2*W-1:0] expq[$];
    string          tagq[$];

    // reference model state
    logic [6:0]  m_pn7  = '1;
    logic [14:0] m_pn15 = '1;
    logic [15:0] m_k    = '0;
    bit          m_armed = 0;
    logic [2*W-1:0] last_exp = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_of(input logic [3:0] s, input logic [15:0] d,
                                              input logic [15:0] l, input logic dv,
                                              input logic dvs, input logic [15:0] p7,
                                              input logic [15:0] p15);
        case (s)
            4'h2: return (!m_armed && dv && dvs) ? d : 16'h0;
            4'h3: return 16'h0;
            4'h4: return ~p7;
            4'h5: return ~p15;
            4'h6: return p7;
            4'h7: return p15;
            4'h8: return l;
            4'hA: return {4{m_k[3:0]}};
            4'hB: return m_k;
            default: return 16'h0;
        endcase
    endfunction

    // Driver: applies one strobe and queues the expected pair.
    task automatic drive(input string tag, input logic [3:0] s0, input logic [3:0] s1,
                         input logic [15:0] d0, input logic [15:0] d1,
                         input logic [15:0] l0, input logic [15:0] l1,
                         input logic dv, input logic dvs);
        logic [15:0] p7;
        logic [15:0] p15;
        logic        fb;
        p7 = '0;
        p15 = '0;
        for (int i = 0; i < 16; i++) begin
            fb = m_pn7[6] ^ m_pn7[5];
            p7 = {p7[14:0], fb};
            m_pn7 = {m_pn7[5:0], fb};
            fb = m_pn15[14] ^ m_pn15[13];
            p15 = {p15[14:0], fb};
            m_pn15 = {m_pn15[13:0], fb};
        end
        chan_sel = {s1, s0};
        dma_data = {d1, d0};
        lb_data = {l1, l0};
        dma_valid = dv;
        dma_valid_sec = dvs;
        last_exp = {expect_of(s1, d1, l1, dv, dvs, p7, p15), expect_of(s0, d0, l0, dv, dvs, p7, p15)};
        expq.push_back(last_exp);
        tagq.push_back(tag);
        m_k = m_k + 1'b1;
        sample_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        sample_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares outputs after each strobe edge.
    always @(posedge clk) fired <= rst_n && sample_en;

    always @(negedge clk) begin
        if (fired === 1'b1) begin
            if (expq.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R2: actual=update expected=no-update");
            end else begin
                chk(tagq.pop_front(), dout, expq.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dout", dout, 32'h0);
        chk("R1 armed", armed, 1'b0);
        chk("R1 dma_ready", dma_ready, 1'b1);
        chk("R1 sync_out", sync_out, 1'b0);

        // R4 loopback and zero
        drive("R4", 4'h8, 4'h3, 16'h1111, 16'h2222, 16'hA5A5, 16'h5A5A, 1'b1, 1'b1);
        drive("R4", 4'h3, 4'h8, 16'h1111, 16'h2222, 16'h0F0F, 16'h1234, 1'b1, 1'b1);

        // R2 hold between strobes while inputs move
        idle(1);
        chan_sel = {4'hB, 4'h6};
        lb_data = 32'hDEADBEEF;
        idle(3);
        chk("R2 hold", dout, last_exp);

        // R3 DMA passing and valid qualification
        drive("R3", 4'h2, 4'h2, 16'hBEEF, 16'h1234, 16'h0, 16'h0, 1'b1, 1'b1);
        drive("R3", 4'h2, 4'h2, 16'hCAFE, 16'h4321, 16'h0, 16'h0, 1'b1, 1'b0);
        drive("R3", 4'h2, 4'h2, 16'hCAFE, 16'h4321, 16'h0, 16'h0, 1'b0, 1'b1);

        // R5 / R6 pseudo-random words, true and inverted
        for (int i = 0; i < 20; i++) drive("R5", 4'h6, 4'h4, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) drive("R6", 4'h7, 4'h5, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);

        // R9 reserved codes
        drive("R9", 4'h0, 4'h1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
        drive("R9", 4'h9, 4'hC, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
        drive("R9", 4'hD, 4'hF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
        drive("R9", 4'hE, 4'hE, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1);

        // R10 channels independent
        drive("R10", 4'h6, 4'hB, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);
        drive("R10", 4'h2, 4'h5, 16'h7777, 16'h0, 16'h0, 16'h0, 1'b1, 1'b1);
        drive("R10", 4'h8, 4'h2, 16'h0, 16'h9999, 16'h3C3C, 16'h0, 1'b1, 1'b1);
        idle(1);

        // R11 arming
        chan_sel = {4'h8, 4'h2};
        dma_valid = 1'b0;
        dma_valid_sec = 1'b0;
        arm_set = 1'b1;
        @(negedge clk);
        arm_set = 1'b0;
        m_armed = 1;
        chk("R11 armed", armed, 1'b1);
        chk("R11 dma_ready", dma_ready, 1'b0);

        // R12 sync_out qualification
        dma_valid = 1'b1;
        #1;
        chk("R12 one valid", sync_out, 1'b0);
        dma_valid_sec = 1'b1;
        #1;
        chk("R12 both valid", sync_out, 1'b1);
        chan_sel = {4'h8, 4'h8};
        #1;
        chk("R12 no dma channel", sync_out, 1'b0);
        @(negedge clk);

        drive("R11", 4'h2, 4'h8, 16'hABCD, 16'h0, 16'h0, 16'h5555, 1'b1, 1'b1);
        idle(1);

        // R13 release by sync
        ext_sync_in = 1'b1;
        @(negedge clk);
        ext_sync_in = 1'b0;
        m_armed = 0;
        chk("R13 released", armed, 1'b0);
        chk("R13 dma_ready", dma_ready, 1'b1);
        chk("R13 sync_out low", sync_out, 1'b0);
        drive("R13", 4'h2, 4'h8, 16'hABCD, 16'h0, 16'h0, 16'h6666, 1'b1, 1'b1);
        idle(1);

        // R13 arm wins over simultaneous sync
        arm_set = 1'b1;
        ext_sync_in = 1'b1;
        @(negedge clk);
        arm_set = 1'b0;
        ext_sync_in = 1'b0;
        m_armed = 1;
        chk("R13 arm priority", armed, 1'b1);
        ext_sync_in = 1'b1;
        @(negedge clk);
        ext_sync_in = 1'b0;
        m_armed = 0;
        chk("R13 second release", armed, 1'b0);
        ext_sync_in = 1'b1;
        @(negedge clk);
        ext_sync_in = 1'b0;
        chk("R13 sync ignored when idle", armed, 1'b0);

        // R7 / R8 ramps across wrap-around
        for (int i = 0; i < 65540; i++)
            drive("R7/R8", 4'hB, 4'hA, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);
        idle(3);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule